// File: doc/BRIEF.md
# Dual-Port Synchronous RAM with Register Stall

This block is a shared memory of 4096 words of 9 bits with two identical access ports, A and B. On a rising clock edge each port captures its address, write data, select and direction into input registers. In the cycle that follows, the port either commits a write or fetches a read word. A per-port stall input freezes the address and data registers without touching the clock. This allows interleaved accesses in which one address is held over several edges. A registered select that is inactive parks the port and raises its power-down flag.

Read data comes out on a plain 9-bit bus together with a drive flag that stands in for a tri-state pin. The drive flag is qualified by an output-enable input. That input acts combinationally, outside the clocked pipeline, so a bus owner can release the bus at any time. When both ports write one word on the same edge, the rule is fixed: port A's data is stored and a one-cycle collision flag is raised. Both ports run from one common clock, so the same-edge collision rule is well defined.

Top module: `dpram_sync`

## Requirements
- R1: The storage holds 4096 words of 9 bits. Each port can write and read back any address from 0x000 to 0xFFF, including both end addresses.
- R2: On a rising edge a port captures its select (active low), direction (1 = read, 0 = write), address and data. A write whose select was low and direction 0 at edge k is committed to the array at edge k+1, and a later read returns it.
- R3: While the stall input is 1 at an edge, the address and data registers keep their contents and select and direction are still sampled. A write issued under stall lands at the held address with the held data and leaves the presented address untouched.
- R4: During reset and until the first access, each port is deselected: power-down is 1, drive is 0 and the collision flag is 0. The registers come out of reset loaded, not stalled.
- R5: A select sampled high at an edge deselects the port from that edge. Power-down goes to 1, no write reaches the array, and the read pipeline is emptied one edge later. A select sampled low clears power-down.
- R6: A read presented before edge k produces its data and drive = 1 after edge k+1. Drive stays 0 after an edge that did not complete a read, and the data bus is meaningful only while drive is 1.
- R7: A read captured at the same edge as another port's write to that address returns the word as it was before that write.
- R8: The output-enable input is active low. When it is 1, the port's drive flag is 0 immediately, with no clock edge needed. Returning it to 0 restores drive for a completed read.
- R9: If both ports write the same address from the same edge, port A's data is kept. The collision flag is 1 for the single cycle after the commit edge and is 0 in all other cycles.
- R10: Simultaneous accesses by the two ports to different addresses do not disturb each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common rising-edge clock for both ports |
| rstN | input | 1 | Asynchronous active-low reset of the port and pipeline registers |
| aSelN | input | 1 | Port A select, active low, registered |
| aRdWr | input | 1 | Port A direction, 1 read, 0 write, registered |
| aHold | input | 1 | Port A stall, 1 freezes address and data registers |
| aOeN | input | 1 | Port A output enable, active low, combinational |
| aAddr | input | 12 | Port A address |
| aDin | input | 9 | Port A write data |
| aDout | output | 9 | Port A read data, valid while aDrive is 1 |
| aDrive | output | 1 | Port A bus drive flag |
| aPowerDown | output | 1 | Port A deselected / power-down flag |
| bSelN | input | 1 | Port B select, active low, registered |
| bRdWr | input | 1 | Port B direction, 1 read, 0 write, registered |
| bHold | input | 1 | Port B stall, 1 freezes address and data registers |
| bOeN | input | 1 | Port B output enable, active low, combinational |
| bAddr | input | 12 | Port B address |
| bDin | input | 9 | Port B write data |
| bDout | output | 9 | Port B read data, valid while bDrive is 1 |
| bDrive | output | 1 | Port B bus drive flag |
| bPowerDown | output | 1 | Port B deselected / power-down flag |
| collide | output | 1 | One-cycle flag for a same-address write by both ports |

## Verification
The clocked properties assume that select, direction, stall, address and data settle well away from the rising edge. The stimulus meets this by changing every one of these inputs only on the falling edge. The drive property assumes that output enable is steady at the rising edge. The bench therefore toggles output enable only inside the low half of a cycle and restores it before the next rising edge. Reads are only issued to words that the same run has already written, so no check depends on uninitialised array contents.

// File: rtl/dpram_pkg.sv
package dpram_pkg;
  // per-port strobes passed from control to the datapath
  typedef struct packed {
    logic wrStb;
    logic rdStb;
  } portStb_t;
endpackage

// File: rtl/dpram_port_ctrl.sv
module dpram_port_ctrl
  import dpram_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          selN,
  input  logic          rdWr,
  input  logic          holdRegs,
  input  logic [AW-1:0] addrIn,
  input  logic [DW-1:0] dataIn,
  output logic [AW-1:0] addrQ,
  output logic [DW-1:0] dataQ,
  output portStb_t      stb,
  output logic          powerDown
);
  logic selQ;
  logic rdWrQ;

  // address/data stall under holdRegs, control always sampled
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
      selQ  <= 1'b0;
      rdWrQ <= 1'b1;
    end else begin
      if (!holdRegs) begin
        addrQ <= addrIn;
        dataQ <= dataIn;
      end
      selQ  <= ~selN;
      rdWrQ <= rdWr;
    end
  end

  always_comb begin
    stb.wrStb = selQ & ~rdWrQ;
    stb.rdStb = selQ & rdWrQ;
    powerDown = ~selQ;
  end

  // R3
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    holdRegs |=> ($stable(addrQ) && $stable(dataQ)));

  // R2
  reg_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    !holdRegs |=> (addrQ == $past(addrIn) && dataQ == $past(dataIn)));

  // R5
  deselect_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    selN |=> (powerDown && !stb.wrStb && !stb.rdStb));
endmodule

// File: rtl/dpram_core.sv
module dpram_core
  import dpram_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rstN,
  input  portStb_t      stbA,
  input  logic [AW-1:0] addrA,
  input  logic [DW-1:0] dataA,
  input  logic          oeNA,
  input  portStb_t      stbB,
  input  logic [AW-1:0] addrB,
  input  logic [DW-1:0] dataB,
  input  logic          oeNB,
  output logic [DW-1:0] rdDataA,
  output logic [DW-1:0] rdDataB,
  output logic          driveA,
  output logic          driveB,
  output logic          collide
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic          rdValidA;
  logic          rdValidB;
  logic          sameWord;

  assign sameWord = stbA.wrStb & stbB.wrStb & (addrA == addrB);

  // array and read registers; reads see contents before this edge's write
  always_ff @(posedge clk) begin
    if (stbB.wrStb && !sameWord) mem[addrB] <= dataB;
    if (stbA.wrStb) mem[addrA] <= dataA;
    if (stbA.rdStb) rdDataA <= mem[addrA];
    if (stbB.rdStb) rdDataB <= mem[addrB];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValidA <= 1'b0;
      rdValidB <= 1'b0;
      collide  <= 1'b0;
    end else begin
      rdValidA <= stbA.rdStb;
      rdValidB <= stbB.rdStb;
      collide  <= sameWord;
    end
  end

  // output enable acts without the clock
  assign driveA = rdValidA & ~oeNA;
  assign driveB = rdValidB & ~oeNB;

  // R9
  collide_raise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stbA.wrStb && stbB.wrStb && addrA == addrB) |=> collide);

  // R9
  collide_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    collide |-> $past(stbA.wrStb && stbB.wrStb));

  // R6
  drive_a_origin_chk: assert property (@(posedge clk) disable iff (!rstN)
    driveA |-> $past(stbA.rdStb));

  // R6
  drive_b_origin_chk: assert property (@(posedge clk) disable iff (!rstN)
    driveB |-> $past(stbB.rdStb));
endmodule

// File: rtl/dpram_sync.sv
module dpram_sync
  import dpram_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          aSelN,
  input  logic          aRdWr,
  input  logic          aHold,
  input  logic          aOeN,
  input  logic [AW-1:0] aAddr,
  input  logic [DW-1:0] aDin,
  output logic [DW-1:0] aDout,
  output logic          aDrive,
  output logic          aPowerDown,
  input  logic          bSelN,
  input  logic          bRdWr,
  input  logic          bHold,
  input  logic          bOeN,
  input  logic [AW-1:0] bAddr,
  input  logic [DW-1:0] bDin,
  output logic [DW-1:0] bDout,
  output logic          bDrive,
  output logic          bPowerDown,
  output logic          collide
);
  localparam int NPORT = 2;

  logic [NPORT-1:0] selN;
  logic [NPORT-1:0] rdWr;
  logic [NPORT-1:0] hold;
  logic [NPORT-1:0] pwrDn;
  logic [AW-1:0]    addrIn [NPORT];
  logic [DW-1:0]    dataIn [NPORT];
  logic [AW-1:0]    addrQ  [NPORT];
  logic [DW-1:0]    dataQ  [NPORT];
  portStb_t         stb    [NPORT];

  assign selN = {bSelN, aSelN};
  assign rdWr = {bRdWr, aRdWr};
  assign hold = {bHold, aHold};
  assign addrIn[0] = aAddr;
  assign addrIn[1] = bAddr;
  assign dataIn[0] = aDin;
  assign dataIn[1] = bDin;

  for (genvar p = 0; p < NPORT; p++) begin : gPort
    dpram_port_ctrl #(.AW(AW), .DW(DW)) uCtrl (
      .clk      (clk),
      .rstN     (rstN),
      .selN     (selN[p]),
      .rdWr     (rdWr[p]),
      .holdRegs (hold[p]),
      .addrIn   (addrIn[p]),
      .dataIn   (dataIn[p]),
      .addrQ    (addrQ[p]),
      .dataQ    (dataQ[p]),
      .stb      (stb[p]),
      .powerDown(pwrDn[p])
    );
  end

  assign aPowerDown = pwrDn[0];
  assign bPowerDown = pwrDn[1];

  dpram_core #(.AW(AW), .DW(DW)) uCore (
    .clk    (clk),
    .rstN   (rstN),
    .stbA   (stb[0]),
    .addrA  (addrQ[0]),
    .dataA  (dataQ[0]),
    .oeNA   (aOeN),
    .stbB   (stb[1]),
    .addrB  (addrQ[1]),
    .dataB  (dataQ[1]),
    .oeNB   (bOeN),
    .rdDataA(aDout),
    .rdDataB(bDout),
    .driveA (aDrive),
    .driveB (bDrive),
    .collide(collide)
  );
endmodule

// File: tb/dpram_sync_test.sv
`timescale 1ns/1ps
module dpram_sync_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        aSelN = 1'b1, aRdWr = 1'b1, aHold = 1'b0, aOeN = 1'b0;
  logic        bSelN = 1'b1, bRdWr = 1'b1, bHold = 1'b0, bOeN = 1'b0;
  logic [11:0] aAddr = '0, bAddr = '0;
  logic [8:0]  aDin = '0, bDin = '0;
  logic [8:0]  aDout, bDout;
  logic        aDrive, bDrive, aPowerDown, bPowerDown, collide;
  int          errors = 0;
  int          checks = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  dpram_sync uut (
    .clk(clk), .rstN(rstN),
    .aSelN(aSelN), .aRdWr(aRdWr), .aHold(aHold), .aOeN(aOeN),
    .aAddr(aAddr), .aDin(aDin), .aDout(aDout), .aDrive(aDrive),
    .aPowerDown(aPowerDown),
    .bSelN(bSelN), .bRdWr(bRdWr), .bHold(bHold), .bOeN(bOeN),
    .bAddr(bAddr), .bDin(bDin), .bDout(bDout), .bDrive(bDrive),
    .bPowerDown(bPowerDown), .collide(collide)
  );

  typedef struct packed {
    logic        aOn;  logic aWr; logic [11:0] aAdr; logic [8:0] aDat;
    logic        bOn;  logic bWr; logic [11:0] bAdr; logic [8:0] bDat;
    logic        aChk; logic [8:0] aExp;
    logic        bChk; logic [8:0] bExp;
    logic        coll;
  } vec_t;

  // each row: inputs applied after checking outputs at the same falling edge
  localparam vec_t TBL [13] = '{
    '{1'b1,1'b1,12'h005,9'h1A5, 1'b1,1'b1,12'h010,9'h022, 1'b0,9'h000, 1'b0,9'h000, 1'b0},
    '{1'b0,1'b0,12'h000,9'h000, 1'b1,1'b1,12'h0FF,9'h0C3, 1'b0,9'h000, 1'b0,9'h000, 1'b0},
    '{1'b1,1'b0,12'h0FF,9'h000, 1'b1,1'b0,12'h005,9'h000, 1'b0,9'h000, 1'b0,9'h000, 1'b0},
    '{1'b1,1'b1,12'h010,9'h111, 1'b1,1'b0,12'h010,9'h000, 1'b0,9'h000, 1'b0,9'h000, 1'b0},
    '{1'b1,1'b0,12'h010,9'h000, 1'b0,1'b0,12'h000,9'h000, 1'b1,9'h0C3, 1'b1,9'h1A5, 1'b0},
    '{1'b0,1'b0,12'h000,9'h000, 1'b0,1'b0,12'h000,9'h000, 1'b0,9'h000, 1'b1,9'h022, 1'b0},
    '{1'b1,1'b1,12'h123,9'h0AA, 1'b1,1'b1,12'h123,9'h155, 1'b1,9'h111, 1'b0,9'h000, 1'b0},
    '{1'b1,1'b1,12'hFFF,9'h1FF, 1'b1,1'b1,12'h000,9'h100, 1'b0,9'h000, 1'b0,9'h000, 1'b0},
    '{1'b1,1'b0,12'h123,9'h000, 1'b0,1'b0,12'h000,9'h000, 1'b0,9'h000, 1'b0,9'h000, 1'b1},
    '{1'b1,1'b0,12'h000,9'h000, 1'b1,1'b0,12'hFFF,9'h000, 1'b0,9'h000, 1'b0,9'h000, 1'b0},
    '{1'b0,1'b0,12'h000,9'h000, 1'b0,1'b0,12'h000,9'h000, 1'b1,9'h0AA, 1'b0,9'h000, 1'b0},
    '{1'b0,1'b0,12'h000,9'h000, 1'b0,1'b0,12'h000,9'h000, 1'b1,9'h100, 1'b1,9'h1FF, 1'b0},
    '{1'b0,1'b0,12'h000,9'h000, 1'b0,1'b0,12'h000,9'h000, 1'b0,9'h000, 1'b0,9'h000, 1'b0}
  };

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic portA(input logic sel, input logic wr, input logic hld,
                       input logic [11:0] adr, input logic [8:0] dat);
    aSelN = ~sel; aRdWr = ~wr; aHold = hld; aAddr = adr; aDin = dat;
  endtask

  task automatic portB(input logic sel, input logic wr,
                       input logic [11:0] adr, input logic [8:0] dat);
    bSelN = ~sel; bRdWr = ~wr; bAddr = adr; bDin = dat;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog (all requirements): actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R4: reset state
    repeat (3) @(negedge clk);
    check("R4 aPowerDown in reset", {11'b0, aPowerDown}, 12'd1);
    check("R4 bPowerDown in reset", {11'b0, bPowerDown}, 12'd1);
    check("R4 drive in reset", {10'b0, aDrive, bDrive}, 12'd0);
    check("R4 collide in reset", {11'b0, collide}, 12'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R4 aPowerDown after reset", {11'b0, aPowerDown}, 12'd1);

    // R1 R2 R6 R7 R9 R10: vector table
    for (int i = 0; i < 13; i++) begin
      @(negedge clk);
      check($sformatf("R6 aDrive step %0d", i), {11'b0, aDrive}, {11'b0, TBL[i].aChk});
      check($sformatf("R6 bDrive step %0d", i), {11'b0, bDrive}, {11'b0, TBL[i].bChk});
      if (TBL[i].aChk)
        check($sformatf("R1/R2/R10 aDout step %0d", i), {3'b0, aDout}, {3'b0, TBL[i].aExp});
      if (TBL[i].bChk)
        check($sformatf("R2/R7/R10 bDout step %0d", i), {3'b0, bDout}, {3'b0, TBL[i].bExp});
      check($sformatf("R9 collide step %0d", i), {11'b0, collide}, {11'b0, TBL[i].coll});
      portA(TBL[i].aOn, TBL[i].aWr, 1'b0, TBL[i].aAdr, TBL[i].aDat);
      portB(TBL[i].bOn, TBL[i].bWr, TBL[i].bAdr, TBL[i].bDat);
    end

    // R5: deselect blocks writes and raises power-down
    portA(1'b1, 1'b0, 1'b0, 12'h005, 9'h000);   // read 005
    @(negedge clk);
    check("R5 aPowerDown selected", {11'b0, aPowerDown}, 12'd0);
    portA(1'b0, 1'b1, 1'b0, 12'h005, 9'h000);   // deselected write attempt
    @(negedge clk);
    check("R5 aPowerDown deselected", {11'b0, aPowerDown}, 12'd1);
    check("R6 aDrive read in flight", {11'b0, aDrive}, 12'd1);
    check("R6 aDout before deselect", {3'b0, aDout}, 12'h1A5);
    portA(1'b1, 1'b0, 1'b0, 12'h005, 9'h000);   // read 005 again
    @(negedge clk);
    check("R5 aDrive after deselect", {11'b0, aDrive}, 12'd0);
    portA(1'b0, 1'b0, 1'b0, 12'h000, 9'h000);
    @(negedge clk);
    check("R5 word kept after deselected write", {3'b0, aDout}, 12'h1A5);

    // R3: stall keeps address and data registers
    portA(1'b1, 1'b1, 1'b0, 12'h300, 9'h055);
    @(negedge clk);
    portA(1'b1, 1'b1, 1'b0, 12'h200, 9'h0AB);
    @(negedge clk);
    portA(1'b1, 1'b1, 1'b1, 12'h300, 9'h0EE);   // stalled write
    @(negedge clk);
    portA(1'b1, 1'b0, 1'b0, 12'h300, 9'h000);
    @(negedge clk);
    portA(1'b1, 1'b0, 1'b0, 12'h200, 9'h000);
    @(negedge clk);
    check("R3 presented address untouched", {3'b0, aDout}, 12'h055);
    portA(1'b0, 1'b0, 1'b0, 12'h000, 9'h000);
    @(negedge clk);
    check("R3 held address holds held data", {3'b0, aDout}, 12'h0AB);

    // R8: output enable acts without a clock edge
    check("R8 aDrive with oe low", {11'b0, aDrive}, 12'd1);
    aOeN = 1'b1;
    #0.5;
    check("R8 aDrive with oe high", {11'b0, aDrive}, 12'd0);
    aOeN = 1'b0;
    #0.5;
    check("R8 aDrive restored", {11'b0, aDrive}, 12'd1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule